// File: doc/BRIEF.md
# Two-Stage Cascaded Priority Interrupt Controller

This block gathers interrupt requests from up to fifteen sources and presents one request line to a processor. It holds two identical eight-line resolver units. The first unit talks to the processor directly. The second unit's request output feeds one line of the first unit, so a whole group of eight sources competes as a single entry at the first unit. Each unit records which requests are waiting and which are being serviced. It grants the processor's acknowledge to the most urgent request that is allowed to run. On that acknowledge it produces an 8-bit vector made of a 5-bit programmable base joined to the winning line number.

The processor acknowledges with a one-cycle strobe and reads the vector one cycle later. It reports the end of each service routine with a separate strobe to each unit. A single mode input selects between two policies. In nested mode, a strictly more urgent request may pre-empt one that is in service. In sequential mode, nothing is granted while any request of that unit is in service.

Source numbering on `req_i` is as follows. Bits 0, 1 and 3 to 7 are the first unit's own lines. Bit 2 is occupied by the link to the second unit. Bits 8 to 15 are the second unit's lines 0 to 7.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: After synchronous reset, `intr_o` and `vec_valid_o` are low and no request is waiting or in service.
- R2: A request is captured on a low-to-high transition of its `req_i` bit. `intr_o` is high at the sample after that edge is clocked in. A line held high after being acknowledged does not request again until it falls and rises.
- R3: Priority is fixed, with line 0 the most urgent and line 7 the least. The vector is {base[4:0], line[2:0]}: `mst_base_i` for the first unit and `slv_base_i` for the second. `vec_valid_o` is high for exactly the cycle after the accepted acknowledge.
- R4: An accepted acknowledge clears the winner's waiting flag and marks it in service. `intr_o` then drops unless another waiting request may still be granted.
- R5: With `nested_i` high, a waiting request raises `intr_o` only if its line number is strictly lower than that of every in-service line of its unit.
- R6: With `nested_i` low, `intr_o` stays low while any line of the first unit is in service. Requests arriving meanwhile are kept and are granted in priority order after the end-of-service strobes.
- R7: An end-of-service strobe clears only the most urgent in-service line of its unit. Lower in-service lines stay in service.
- R8: `req_i[2]` has no effect: it never raises `intr_o` and never yields a vector.
- R9: A request on `req_i[8+k]` is routed through the second unit and ranks at the first unit as line 2. When it wins, the vector is {`slv_base_i`, k}, and the first unit contributes no vector.
- R10: An acknowledge while `intr_o` is low produces no vector and changes no state.
- R11: `eoi_slv_i` ends service in the second unit only. The first unit's line 2 stays in service, and keeps blocking lower or equal lines, until `eoi_mst_i` is strobed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 16 | Request lines; bit 2 unused, bits 8..15 go to the second unit |
| nested_i | input | 1 | 1 = nested pre-emption, 0 = sequential servicing |
| mst_base_i | input | 5 | Vector base of the first unit |
| slv_base_i | input | 5 | Vector base of the second unit |
| inta_i | input | 1 | Processor acknowledge strobe, one cycle |
| eoi_mst_i | input | 1 | End-of-service strobe for the first unit |
| eoi_slv_i | input | 1 | End-of-service strobe for the second unit |
| intr_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 8 | Vector of the last accepted acknowledge |
| vec_valid_o | output | 1 | High for the one cycle in which `vec_o` is fresh |

## Verification
The checks assume the processor's side behaves well: the acknowledge is a single-cycle strobe, an end-of-service strobe never shares a cycle with an acknowledge, and both vector bases stay steady around an acknowledge. The directed tasks drive every strobe and every request edge for one cycle from the falling clock edge. They leave at least one idle cycle between an acknowledge and any end-of-service strobe, and they set the bases once before reset is released, so stimulus never leaves that envelope.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int unsigned LINES        = 8;
    localparam int unsigned IDX_W        = $clog2(LINES);
    localparam int unsigned VEC_W        = 8;
    localparam int unsigned BASE_W       = VEC_W - IDX_W;
    localparam int unsigned CASC_LINE_DEF = 2;
    localparam int unsigned UNITS        = 2;

    typedef logic [LINES-1:0]  line_vec_t;
    typedef logic [IDX_W-1:0]  line_idx_t;
    typedef logic [BASE_W-1:0] base_t;
    typedef logic [VEC_W-1:0]  vec_t;

    // Result of a fixed-priority search: any bit found, and the lowest index.
    typedef struct packed {
        logic      any;
        line_idx_t idx;
    } pick_t;

    function automatic pick_t first_set(line_vec_t v);
        pick_t p;
        p = '0;
        for (int i = int'(LINES) - 1; i >= 0; i--) begin
            if (v[i]) begin
                p.any = 1'b1;
                p.idx = line_idx_t'(i);
            end
        end
        return p;
    endfunction

    function automatic vec_t make_vec(base_t b, line_idx_t i);
        return {b, i};
    endfunction

endpackage

// File: rtl/irq_prio_resolve.sv
module irq_prio_resolve
    import irq_pkg::*;
(
    input  line_vec_t pend_i,
    input  line_vec_t isr_i,
    input  logic      nested_i,
    output pick_t     win_o,
    output pick_t     act_o,
    output logic      serve_o
);

    pick_t win_c;
    pick_t act_c;

    always_comb begin
        win_c = first_set(pend_i);
        act_c = first_set(isr_i);
        // Grant only if nothing is in service, or (nested) the candidate
        // strictly outranks the most urgent in-service line.
        serve_o = win_c.any &&
                  (!act_c.any || (nested_i && (win_c.idx < act_c.idx)));
    end

    assign win_o = win_c;
    assign act_o = act_c;

endmodule

// File: rtl/irq_unit.sv
module irq_unit
    import irq_pkg::*;
#(
    parameter bit          HAS_CASC  = 1'b0,
    parameter int unsigned CASC_LINE = CASC_LINE_DEF
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      nested_i,
    input  line_vec_t req_i,
    input  logic      casc_lvl_i,
    input  logic      ack_i,
    input  logic      eoi_i,
    output logic      intr_o,
    output logic      take_o,
    output line_idx_t win_idx_o
);

    // The cascade line is a live level from the downstream unit; its own
    // request pin and waiting flag are suppressed.
    localparam line_vec_t CASC_MASK =
        HAS_CASC ? (line_vec_t'(1) << CASC_LINE) : line_vec_t'(0);

    line_vec_t req_q, pend_q, isr_q;
    line_vec_t pend_n, isr_n;
    line_vec_t eff_pend, rise;
    pick_t     win, act;
    logic      serve, take;

    assign eff_pend = pend_q | (CASC_MASK & {LINES{casc_lvl_i}});
    assign rise     = req_i & ~req_q & ~CASC_MASK;

    irq_prio_resolve u_resolve (
        .pend_i   (eff_pend),
        .isr_i    (isr_q),
        .nested_i (nested_i),
        .win_o    (win),
        .act_o    (act),
        .serve_o  (serve)
    );

    assign take = ack_i & serve;

    always_comb begin
        pend_n = pend_q;
        if (take) begin
            pend_n[win.idx] = 1'b0;
        end
        pend_n = (pend_n | rise) & ~CASC_MASK;

        isr_n = isr_q;
        if (eoi_i && act.any) begin
            isr_n[act.idx] = 1'b0;
        end
        if (take) begin
            isr_n[win.idx] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= '0;
            pend_q <= '0;
            isr_q  <= '0;
        end else begin
            req_q  <= req_i;
            pend_q <= pend_n;
            isr_q  <= isr_n;
        end
    end

    assign intr_o    = serve;
    assign take_o    = take;
    assign win_idx_o = win.idx;

endmodule

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl
    import irq_pkg::*;
#(
    parameter int unsigned CASC_LINE = CASC_LINE_DEF
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [UNITS*LINES-1:0]  req_i,
    input  logic                    nested_i,
    input  logic [BASE_W-1:0]       mst_base_i,
    input  logic [BASE_W-1:0]       slv_base_i,
    input  logic                    inta_i,
    input  logic                    eoi_mst_i,
    input  logic                    eoi_slv_i,
    output logic                    intr_o,
    output logic [VEC_W-1:0]        vec_o,
    output logic                    vec_valid_o
);

    localparam line_idx_t CASC_IDX = line_idx_t'(CASC_LINE);

    logic      u_intr [UNITS];
    logic      u_take [UNITS];
    logic      u_ack  [UNITS];
    logic      u_lvl  [UNITS];
    logic      u_eoi  [UNITS];
    line_idx_t u_win  [UNITS];
    logic      to_casc;

    // Unit 0 faces the processor; unit 1 hangs off unit 0's cascade line.
    assign u_ack[0] = inta_i;
    assign u_ack[1] = to_casc;
    assign u_lvl[0] = u_intr[1];
    assign u_lvl[1] = 1'b0;
    assign u_eoi[0] = eoi_mst_i;
    assign u_eoi[1] = eoi_slv_i;

    for (genvar u = 0; u < UNITS; u++) begin : g_unit
        irq_unit #(
            .HAS_CASC  (u == 0),
            .CASC_LINE (CASC_LINE)
        ) u_core (
            .clk        (clk),
            .rst        (rst),
            .nested_i   (nested_i),
            .req_i      (req_i[u*LINES +: LINES]),
            .casc_lvl_i (u_lvl[u]),
            .ack_i      (u_ack[u]),
            .eoi_i      (u_eoi[u]),
            .intr_o     (u_intr[u]),
            .take_o     (u_take[u]),
            .win_idx_o  (u_win[u])
        );
    end

    assign to_casc = u_take[0] && (u_win[0] == CASC_IDX);

    // Vector stage: the downstream unit owns the vector whenever the
    // acknowledge was forwarded to it.
    vec_t vec_q;
    logic vld_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= (u_take[0] & ~to_casc) | u_take[1];
            if (u_take[1]) begin
                vec_q <= make_vec(slv_base_i, u_win[1]);
            end else if (u_take[0]) begin
                vec_q <= make_vec(mst_base_i, u_win[0]);
            end
        end
    end

    assign intr_o      = u_intr[0];
    assign vec_o       = vec_q;
    assign vec_valid_o = vld_q;

endmodule

// File: rtl/irq_cascade_ctrl_chk.sv
module irq_cascade_ctrl_chk
    import irq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              inta_i,
    input logic              eoi_mst_i,
    input logic              eoi_slv_i,
    input logic [BASE_W-1:0] mst_base_i,
    input logic [BASE_W-1:0] slv_base_i,
    input logic              intr_o,
    input logic [VEC_W-1:0]  vec_o,
    input logic              vec_valid_o
);

    p_quiet_after_rst_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!intr_o && !vec_valid_o));

    p_vec_needs_grant_r10: assert property (@(posedge clk) disable iff (rst)
        vec_valid_o |-> $past(inta_i && intr_o));

    p_vec_base_r3: assert property (@(posedge clk) disable iff (rst)
        vec_valid_o |-> ((vec_o[VEC_W-1:IDX_W] == $past(mst_base_i)) ||
                         (vec_o[VEC_W-1:IDX_W] == $past(slv_base_i))));

    p_vld_one_cycle_r3: assert property (@(posedge clk) disable iff (rst)
        (vec_valid_o && !inta_i) |=> !vec_valid_o);

    p_ack_strobe_r4: assert property (@(posedge clk) disable iff (rst)
        inta_i |=> !inta_i);

    p_eoi_apart_r7: assert property (@(posedge clk) disable iff (rst)
        inta_i |-> (!eoi_mst_i && !eoi_slv_i));

endmodule

bind irq_cascade_ctrl irq_cascade_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .inta_i      (inta_i),
    .eoi_mst_i   (eoi_mst_i),
    .eoi_slv_i   (eoi_slv_i),
    .mst_base_i  (mst_base_i),
    .slv_base_i  (slv_base_i),
    .intr_o      (intr_o),
    .vec_o       (vec_o),
    .vec_valid_o (vec_valid_o)
);

// File: tb/tb_irq_cascade_ctrl.sv
module tb_irq_cascade_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] req = '0;
    logic        nested = 1'b1;
    logic [4:0]  mbase = 5'b01000;   // vectors 0x40..0x47
    logic [4:0]  sbase = 5'b01110;   // vectors 0x70..0x77
    logic        inta = 1'b0;
    logic        eoi_m = 1'b0;
    logic        eoi_s = 1'b0;
    logic        intr;
    logic [7:0]  vec;
    logic        vvld;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;   // 20 ns period

    irq_cascade_ctrl dut (
        .clk         (clk),
        .rst         (rst),
        .req_i       (req),
        .nested_i    (nested),
        .mst_base_i  (mbase),
        .slv_base_i  (sbase),
        .inta_i      (inta),
        .eoi_mst_i   (eoi_m),
        .eoi_slv_i   (eoi_s),
        .intr_o      (intr),
        .vec_o       (vec),
        .vec_valid_o (vvld)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic chk_intr(input string tag, input logic exp);
        chk(intr === exp, tag, int'(intr), int'(exp));
    endtask

    task automatic pulse_req(input int b);
        req[b] = 1'b1;
        step();
        req[b] = 1'b0;
    endtask

    // Acknowledge, then sample the vector in the cycle it is valid.
    task automatic ack_expect(input string tag, input bit want, input int exp);
        inta = 1'b1;
        step();
        inta = 1'b0;
        if (want) chk(vvld === 1'b1 && int'(vec) == exp, tag, vvld ? int'(vec) : -1, exp);
        else      chk(vvld === 1'b0, tag, int'(vvld), 0);
        step();
    endtask

    task automatic end_m();
        eoi_m = 1'b1;
        step();
        eoi_m = 1'b0;
    endtask

    task automatic end_s();
        eoi_s = 1'b1;
        step();
        eoi_s = 1'b0;
    endtask

    task automatic t_reset();
        chk_intr("R1 intr after reset", 1'b0);
        chk(vvld === 1'b0, "R1 vec_valid after reset", int'(vvld), 0);
    endtask

    task automatic t_single();
        nested = 1'b1;
        pulse_req(5);
        chk_intr("R2 intr after edge", 1'b1);
        inta = 1'b1;
        step();
        inta = 1'b0;
        chk(vvld === 1'b1 && vec == 8'h45, "R3 vector line5", int'(vec), 'h45);
        chk_intr("R4 intr drops after grant", 1'b0);
        step();
        chk(vvld === 1'b0, "R3 valid lasts one cycle", int'(vvld), 0);
        end_m();
        // Held-high line requests only once.
        req[4] = 1'b1;
        step();
        chk_intr("R2 held line requests", 1'b1);
        ack_expect("R2 held line vector", 1'b1, 'h44);
        step();
        end_m();
        step();
        chk_intr("R2 held line no repeat", 1'b0);
        req[4] = 1'b0;
        step();
    endtask

    task automatic t_priority();
        nested = 1'b1;
        req[6] = 1'b1;
        req[1] = 1'b1;
        step();
        req = '0;
        ack_expect("R3 line1 beats line6", 1'b1, 'h41);
        chk_intr("R5 lower line blocked in nested", 1'b0);
        end_m();
        chk_intr("R4 line6 after end", 1'b1);
        ack_expect("R3 line6 vector", 1'b1, 'h46);
        end_m();
        chk_intr("R4 idle", 1'b0);
    endtask

    task automatic t_nested();
        nested = 1'b1;
        pulse_req(5);
        ack_expect("R5 first grant", 1'b1, 'h45);
        pulse_req(6);
        chk_intr("R5 lower waits", 1'b0);
        pulse_req(5);
        chk_intr("R5 equal waits", 1'b0);
        pulse_req(1);
        chk_intr("R5 higher pre-empts", 1'b1);
        ack_expect("R5 nested vector", 1'b1, 'h41);
        pulse_req(3);
        chk_intr("R5 line3 below line1", 1'b0);
        end_m();
        chk_intr("R7 end cleared line1 only", 1'b1);
        ack_expect("R7 line3 nests over line5", 1'b1, 'h43);
        end_m();
        chk_intr("R7 line5 still in service", 1'b0);
        end_m();
        chk_intr("R7 all ended", 1'b1);
        ack_expect("R7 waiting line5", 1'b1, 'h45);
        end_m();
        ack_expect("R7 waiting line6", 1'b1, 'h46);
        end_m();
        chk_intr("R7 idle", 1'b0);
    endtask

    task automatic t_sequential();
        nested = 1'b0;
        pulse_req(4);
        ack_expect("R6 first grant", 1'b1, 'h44);
        pulse_req(0);
        chk_intr("R6 no pre-emption", 1'b0);
        pulse_req(7);
        chk_intr("R6 still blocked", 1'b0);
        end_m();
        chk_intr("R6 kept request", 1'b1);
        ack_expect("R6 line0 first", 1'b1, 'h40);
        end_m();
        ack_expect("R6 line7 next", 1'b1, 'h47);
        end_m();
        chk_intr("R6 idle", 1'b0);
        nested = 1'b1;
    endtask

    task automatic t_link_pin();
        pulse_req(2);
        chk_intr("R8 bit2 ignored", 1'b0);
        step();
        chk_intr("R8 bit2 ignored later", 1'b0);
        ack_expect("R8 no vector", 1'b0, 0);
    endtask

    task automatic t_spurious();
        ack_expect("R10 ack while idle", 1'b0, 0);
        chk_intr("R10 intr stays low", 1'b0);
        pulse_req(3);
        ack_expect("R10 state intact", 1'b1, 'h43);
        end_m();
        chk_intr("R10 idle after", 1'b0);
    endtask

    task automatic t_cascade();
        nested = 1'b1;
        pulse_req(13);
        chk_intr("R9 second unit raises intr", 1'b1);
        ack_expect("R9 second unit vector", 1'b1, 'h75);
        pulse_req(3);
        chk_intr("R9 line3 below link", 1'b0);
        pulse_req(1);
        chk_intr("R9 line1 above link", 1'b1);
        ack_expect("R9 line1 vector", 1'b1, 'h41);
        end_m();
        chk_intr("R9 link still in service", 1'b0);
        pulse_req(9);
        chk_intr("R11 link blocks nest", 1'b0);
        end_s();
        chk_intr("R11 second-unit end only", 1'b0);
        end_m();
        chk_intr("R11 first-unit end frees link", 1'b1);
        ack_expect("R9 second unit line1", 1'b1, 'h71);
        end_s();
        end_m();
        chk_intr("R9 line3 resumes", 1'b1);
        ack_expect("R9 line3 vector", 1'b1, 'h43);
        end_m();
        chk_intr("R9 idle", 1'b0);
    endtask

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();
        t_reset();
        t_single();
        t_priority();
        t_nested();
        t_sequential();
        t_link_pin();
        t_spurious();
        t_cascade();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule